// File: doc/BRIEF.md
# DDR Sample Lane Packer

This block takes the pair of words that double-data-rate input registers deliver on each clock, one captured on the rising edge and one on the falling edge, and turns them into whole converter samples. It then places those samples side by side in one wide word for a storage path that runs on a single system clock. Depending on how the converter drives its output lanes, each clock yields one, two or four samples. This lets the effective sample rate reach up to four times the storage clock. The one exception is the mode in which the two edges carry alternate bits of a single sample, which gives one sample per clock.

A two-bit mode input picks the edge-to-sample mapping. The mode is taken while the block is idle, at the first enabled clock, and is held for as long as the enable stays high. The packed word, a slot-count code and a valid strobe are registered and appear one clock after the input words. Unused sample slots are zero-filled. The lowest slot always carries the earliest sample: rising edge before falling edge, and bus A before bus B.

Top module: `ddrLanePacker`

## Requirements
- R1: After reset, `outValid` is 0, `packedWord` is 0 and `slotCode` is 0.
- R2: With mode code 0 (sample-wise pairs), a fired clock gives `packedWord[7:0]`=`riseA`, `packedWord[15:8]`=`fallA`, zeros above bit 15, and `slotCode`=1.
- R3: With mode code 1 (two buses), a fired clock gives slots 0..3 (8 bits each, slot 0 lowest) equal to `riseA`, `fallA`, `riseB`, `fallB`, with `slotCode`=3. The code value 2 never appears with `outValid` high.
- R4: With mode code 2 (bit-split), `riseA[3:0]` lands on sample bits 0,2,4,6 and `fallA[3:0]` on bits 1,3,5,7, with `riseA[i]` going to bit 2i. The rebuilt sample is in `packedWord[7:0]`, bits above 7 are zero, and `slotCode`=0. `riseA[7:4]`, `fallA[7:4]` and bus B have no effect on the output.
- R5: `outValid` is high exactly one clock after a rising clock edge that sees `enable` high with a legal mode in force. There is never a valid without enable at the previous edge.
- R6: The mode in force is `modeSel` at the first clock of an enabled run. Changes to `modeSel` while `enable` stays high are ignored until `enable` drops and rises again.
- R7: Mode code 3 is reserved. A run started in it produces no valid output, and the output word does not change.
- R8: While `outValid` is low, `packedWord` and `slotCode` keep their last values.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System storage clock |
| rstN | input | 1 | Active-low synchronous reset |
| enable | input | 1 | Run request; low means idle |
| modeSel | input | 2 | Edge-to-sample mapping code, taken when a run starts |
| riseA | input | 8 | Bus A rising-edge word |
| fallA | input | 8 | Bus A falling-edge word |
| riseB | input | 8 | Bus B rising-edge word |
| fallB | input | 8 | Bus B falling-edge word |
| packedWord | output | 32 | Packed samples, earliest in the lowest slot |
| slotCode | output | 2 | Valid slot count minus one |
| outValid | output | 1 | Packed word strobe |

## Verification
The bench switches `modeSel` in the middle of a run. A design that reads the mode live would change its slot code and layout partway through the stream. It also drops and raises `enable` to show that a new mode takes hold only at the next run start. In bit-split mode, noise is driven on the unused upper nibbles and on bus B. A wrong interleave or a leak from those bits shows up as a corrupted low byte or nonzero upper slots. Reserved-mode runs and idle gaps check that the word and code hold still, where a design that clears or rewrites its output register would fail. A design with an extra pipeline stage would miss every comparison on the first cycle of a run.

// File: rtl/ddrPackPkg.sv
package ddrPackPkg;
  localparam int SLOTS = 4;
  localparam int CODE_W = $clog2(SLOTS);

  typedef enum logic [1:0] {
    MODE_PAIR    = 2'd0,
    MODE_DUALBUS = 2'd1,
    MODE_BITSPLIT = 2'd2,
    MODE_RSVD    = 2'd3
  } packMode_e;

  typedef struct packed {
    logic      fire;
    packMode_e mode;
  } packCmd_t;
endpackage

// File: rtl/ddrPackCtrl.sv
module ddrPackCtrl
  import ddrPackPkg::*;
(
  input  logic       clk,
  input  logic       rstN,
  input  logic       enable,
  input  logic [1:0] modeSel,
  output packCmd_t   cmd
);
  logic      running;
  packMode_e heldMode;
  packMode_e effMode;

  // While idle the live code is used; once running, the captured one.
  assign effMode = running ? heldMode : packMode_e'(modeSel);

  always_ff @(posedge clk) begin
    if (!rstN) begin
      running  <= 1'b0;
      heldMode <= MODE_PAIR;
    end else begin
      running <= enable;
      if (enable && !running) heldMode <= effMode;
    end
  end

  always_comb begin
    cmd.fire = enable && (effMode != MODE_RSVD);
    cmd.mode = effMode;
  end
endmodule

// File: rtl/ddrPackDatapath.sv
module ddrPackDatapath
  import ddrPackPkg::*;
#(
  parameter int SAMPLE_W = 8
) (
  input  logic                      clk,
  input  logic                      rstN,
  input  packCmd_t                  cmd,
  input  logic [SAMPLE_W-1:0]       riseA,
  input  logic [SAMPLE_W-1:0]       fallA,
  input  logic [SAMPLE_W-1:0]       riseB,
  input  logic [SAMPLE_W-1:0]       fallB,
  output logic [SAMPLE_W*SLOTS-1:0] packedWord,
  output logic [CODE_W-1:0]         slotCode,
  output logic                      outValid
);
  localparam int HALF_W = SAMPLE_W / 2;
  localparam int WORD_W = SAMPLE_W * SLOTS;

  logic [SAMPLE_W-1:0]              splitSample;
  logic [SLOTS-1:0][SAMPLE_W-1:0]   rawSlots;
  logic [SLOTS-1:0][SAMPLE_W-1:0]   nextSlots;
  logic [CODE_W-1:0]                nextCode;

  // Rebuild one sample from the two half-width edge captures.
  for (genvar i = 0; i < HALF_W; i++) begin : gInterleave
    assign splitSample[2*i]   = riseA[i];
    assign splitSample[2*i+1] = fallA[i];
  end

  // Natural time order of the four edge words.
  assign rawSlots[0] = riseA;
  assign rawSlots[1] = fallA;
  assign rawSlots[2] = riseB;
  assign rawSlots[3] = fallB;

  always_comb begin
    unique case (cmd.mode)
      MODE_DUALBUS:  nextCode = CODE_W'(SLOTS - 1);
      MODE_PAIR:     nextCode = CODE_W'(1);
      default:       nextCode = '0;
    endcase
  end

  // Keep a slot only when it lies inside the valid count; zero the rest.
  for (genvar s = 0; s < SLOTS; s++) begin : gSlot
    always_comb begin
      if (cmd.mode == MODE_BITSPLIT)
        nextSlots[s] = (s == 0) ? splitSample : '0;
      else if (s <= int'(nextCode))
        nextSlots[s] = rawSlots[s];
      else
        nextSlots[s] = '0;
    end
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      packedWord <= '0;
      slotCode   <= '0;
      outValid   <= 1'b0;
    end else begin
      outValid <= cmd.fire;
      if (cmd.fire) begin
        packedWord <= WORD_W'(nextSlots);
        slotCode   <= nextCode;
      end
    end
  end
endmodule

// File: rtl/ddrLanePacker.sv
module ddrLanePacker
  import ddrPackPkg::*;
#(
  parameter int SAMPLE_W = 8
) (
  input  logic                      clk,
  input  logic                      rstN,
  input  logic                      enable,
  input  logic [1:0]                modeSel,
  input  logic [SAMPLE_W-1:0]       riseA,
  input  logic [SAMPLE_W-1:0]       fallA,
  input  logic [SAMPLE_W-1:0]       riseB,
  input  logic [SAMPLE_W-1:0]       fallB,
  output logic [SAMPLE_W*SLOTS-1:0] packedWord,
  output logic [CODE_W-1:0]         slotCode,
  output logic                      outValid
);
  packCmd_t cmd;

  ddrPackCtrl uCtrl (
    .clk(clk), .rstN(rstN), .enable(enable), .modeSel(modeSel), .cmd(cmd)
  );

  ddrPackDatapath #(.SAMPLE_W(SAMPLE_W)) uPath (
    .clk(clk), .rstN(rstN), .cmd(cmd),
    .riseA(riseA), .fallA(fallA), .riseB(riseB), .fallB(fallB),
    .packedWord(packedWord), .slotCode(slotCode), .outValid(outValid)
  );
endmodule

// File: rtl/ddrLanePackerChecker.sv
module ddrLanePackerChecker
  import ddrPackPkg::*;
#(
  parameter int SAMPLE_W = 8
) (
  input logic                      clk,
  input logic                      rstN,
  input logic                      enable,
  input logic [SAMPLE_W*SLOTS-1:0] packedWord,
  input logic [CODE_W-1:0]         slotCode,
  input logic                      outValid
);
  localparam int WORD_W = SAMPLE_W * SLOTS;
  logic pastOk;

  always_ff @(posedge clk) begin
    if (!rstN) pastOk <= 1'b0;
    else       pastOk <= 1'b1;
  end

  assert_valid_needs_enable_R5: assert property (@(posedge clk) disable iff (!rstN)
    (pastOk && !$past(enable)) |-> !outValid);

  assert_code_legal_R3: assert property (@(posedge clk) disable iff (!rstN)
    outValid |-> (slotCode != CODE_W'(2)));

  assert_pair_upper_zero_R2: assert property (@(posedge clk) disable iff (!rstN)
    (outValid && slotCode == CODE_W'(1)) |-> (packedWord[WORD_W-1:2*SAMPLE_W] == '0));

  assert_split_upper_zero_R4: assert property (@(posedge clk) disable iff (!rstN)
    (outValid && slotCode == '0) |-> (packedWord[WORD_W-1:SAMPLE_W] == '0));

  assert_mode_locked_R6: assert property (@(posedge clk) disable iff (!rstN)
    (pastOk && outValid && $past(outValid)) |-> (slotCode == $past(slotCode)));

  assert_hold_idle_R8: assert property (@(posedge clk) disable iff (!rstN)
    (pastOk && $past(rstN) && !outValid) |-> ($stable(packedWord) && $stable(slotCode)));
endmodule

bind ddrLanePacker ddrLanePackerChecker #(.SAMPLE_W(SAMPLE_W)) uChecker (
  .clk(clk), .rstN(rstN), .enable(enable), .packedWord(packedWord),
  .slotCode(slotCode), .outValid(outValid)
);

// File: tb/ddrLanePacker_test.sv
module ddrLanePacker_test;
  logic        clk = 1'b0;
  logic        rstN;
  logic        enable;
  logic [1:0]  modeSel;
  logic [7:0]  riseA, fallA, riseB, fallB;
  logic [31:0] packedWord;
  logic [1:0]  slotCode;
  logic        outValid;

  int vectors = 0;
  int errors  = 0;
  int cycles  = 0;

  // Behavioural reference state.
  bit          mRunning;
  int          mHeld;
  bit          expValid;
  logic [31:0] expWord;
  logic [1:0]  expCode;
  string       expTag;

  always #2.5 clk = ~clk;

  ddrLanePacker uut (
    .clk(clk), .rstN(rstN), .enable(enable), .modeSel(modeSel),
    .riseA(riseA), .fallA(fallA), .riseB(riseB), .fallB(fallB),
    .packedWord(packedWord), .slotCode(slotCode), .outValid(outValid)
  );

  initial begin
    #2000000;
    errors++;
    $display("FAIL watchdog: run did not complete (actual hung, expected done)");
    $display("== %0d vectors applied, %0d miscompares ==", vectors, errors);
    $finish;
  end

  task automatic compare();
    vectors++;
    if (outValid !== expValid || packedWord !== expWord || slotCode !== expCode) begin
      errors++;
      $display("FAIL %s: actual valid=%0b word=%08h code=%0d, expected valid=%0b word=%08h code=%0d",
               expTag, outValid, packedWord, slotCode, expValid, expWord, expCode);
    end
  endtask

  // Predict the result of the coming rising edge from the inputs just driven.
  task automatic predict();
    int eff;
    logic [7:0] s;
    eff = mRunning ? mHeld : int'(modeSel);
    if (enable && !mRunning) mHeld = int'(modeSel);
    mRunning = enable;
    expValid = enable && (eff != 3);
    if (!enable)       expTag = "R8 idle hold";
    else if (eff == 3) expTag = "R7 reserved";
    if (expValid) begin
      case (eff)
        0: begin expWord = {16'h0, fallA, riseA}; expCode = 2'd1; expTag = "R2/R5/R6 pair"; end
        1: begin expWord = {fallB, riseB, fallA, riseA}; expCode = 2'd3; expTag = "R3/R5/R6 dual"; end
        default: begin
          for (int i = 0; i < 4; i++) begin
            s[2*i]   = riseA[i];
            s[2*i+1] = fallA[i];
          end
          expWord = {24'h0, s}; expCode = 2'd0; expTag = "R4/R5/R6 split";
        end
      endcase
    end
  endtask

  // One cycle: drive at negedge, model the posedge, check at the next negedge.
  task automatic step(input bit en, input int mode);
    enable  = en;
    modeSel = 2'(mode);
    riseA = 8'($urandom); fallA = 8'($urandom);
    riseB = 8'($urandom); fallB = 8'($urandom);
    predict();
    @(negedge clk);
    cycles++;
    compare();
  endtask

  task automatic run(input int mode, input int n);
    for (int k = 0; k < n; k++) step(1'b1, mode);
  endtask

  task automatic idle(input int n);
    for (int k = 0; k < n; k++) step(1'b0, int'($urandom_range(0, 3)));
  endtask

  initial begin
    rstN = 1'b0; enable = 1'b0; modeSel = 2'd0;
    riseA = '0; fallA = '0; riseB = '0; fallB = '0;
    mRunning = 0; mHeld = 0;
    expValid = 0; expWord = '0; expCode = '0; expTag = "R1 reset";
    repeat (3) @(negedge clk);
    compare();                       // R1 reset state
    rstN = 1'b1;
    expTag = "R1 after reset";
    idle(2);

    run(0, 20); idle(2);             // R2
    run(1, 20); idle(2);             // R3
    run(2, 20); idle(2);             // R4 with noise on unused bits

    // R6: switch modeSel mid-run, must be ignored
    run(0, 5); run(1, 5); run(2, 5); idle(1);
    // R6: back-to-back re-enable picks the new code
    run(1, 4); idle(1); run(2, 4); idle(1);

    // R7: reserved code, then switch code mid-run stays reserved
    run(3, 6); run(0, 4); idle(2);
    // R5: single-cycle enables
    for (int k = 0; k < 30; k++) begin
      step(1'b1, k % 4);
      idle(k % 3);
    end
    // Random mixed traffic
    for (int k = 0; k < 400; k++) step(1'($urandom_range(0, 3) != 0), int'($urandom_range(0, 3)));

    // R1: reset in the middle of a run clears outputs
    rstN = 1'b0; enable = 1'b1;
    @(negedge clk);
    mRunning = 0; mHeld = 0;
    expValid = 0; expWord = '0; expCode = '0; expTag = "R1 mid-run reset";
    compare();
    rstN = 1'b1;
    run(1, 3); idle(2);

    $display("== %0d vectors applied, %0d miscompares ==", vectors, errors);
    $finish;
  end
endmodule